// File: doc/BRIEF.md
# Memory Test Sequencer with Failure Logging

This block drives a write, read and compare sweep over an address window of a single memory port. For every address it stores the word offered by an external pattern generator, reads the same address back one cycle later, and compares the two under a per-bit check mask. The window bounds, a signed step and the mask are taken from configuration inputs when a test is started. The range and the step are corrected first: a high bound beyond the memory clears down to the last word, a low bound left above the high bound becomes zero, and a step of zero becomes one.

Mismatches feed a set of diagnostic registers: the last expected and observed words, a union of bits seen high that should have been low, a union of bits seen low that should have been high, an AND and an OR of all failing addresses, and 32-bit counts of compared addresses and of failures. In stop-on-error mode the sweep parks after a failing compare and can be resumed. In free-running mode it keeps going and keeps accumulating until the window ends or an abort arrives.

Top module: `mem_test_seq`

## Requirements
- R1: After reset the block is idle (busy, halted and done low), issues no memory strobe, both counters read 0, the address AND register reads all ones and the address OR register reads 0.
- R2: On start, a high bound above MEM_LEN-1 is replaced by MEM_LEN-1; if the low bound then exceeds the high bound, the low bound is replaced by 0. No write is ever issued above MEM_LEN-1.
- R3: A start with an increment of 0 sweeps as if the increment were +1.
- R4: With a positive increment the sweep begins at the low bound and adds the increment after each address, ending with done once the next address would exceed the high bound.
- R5: With a negative increment (two's complement, AW+1 bits) the sweep begins at the high bound and ends with done once the next address would fall below the low bound.
- R6: Each address takes three cycles: a write of the pattern word, a read of the same address in the next cycle, a compare of the read data (one cycle latency) in the cycle after; the pattern advance strobe pulses once per compare.
- R7: A failure is a mismatch in any bit set in the check mask. The picked register ORs in bits masked-in, expected 0 and read 1; the dropped register ORs in bits masked-in, expected 1 and read 0; unmasked bits never fail or log.
- R8: The loop counter (32 bits) increments on every compare and the failure counter (32 bits) on every failing compare; on a failure the expected and observed words are captured and the current-address output shows the last compared address.
- R9: The address AND and address OR registers fold in each failing address; a new start sets them to all ones and zero, a resume keeps them.
- R10: In stop-on-error mode the block halts after the first failing compare; a resume continues with the next address of the window, or goes straight to done if the failing address was the last one.
- R11: In free-running mode failures never halt the sweep; all logs keep accumulating to the end of the window.
- R12: An abort while busy or halted returns the block to idle with no further memory strobes; abort takes priority over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new test with fresh logs |
| resume | input | 1 | Continue a halted test |
| free_run | input | 1 | Mode sampled at start/resume: 1 never halts, 0 halts on failure |
| abort | input | 1 | Stop the test and return to idle |
| cfg_lo | input | AW | Low address bound |
| cfg_hi | input | AW | High address bound |
| cfg_inc | input | AW+1 | Signed address step |
| cfg_mask | input | DW | Bits checked, sampled at start/resume |
| pat_data | input | DW | Pattern word for the current address |
| pat_next | output | 1 | Advance the pattern source |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after mem_re |
| busy | output | 1 | Sweep in progress |
| halted | output | 1 | Parked after a failure |
| done | output | 1 | Window finished |
| cur_addr | output | AW | Last compared address |
| should_be | output | DW | Expected word of the last failure |
| data_was | output | DW | Observed word of the last failure |
| bits_picked | output | DW | Union of bits read 1 that should be 0 |
| bits_dropped | output | DW | Union of bits read 0 that should be 1 |
| addr_and | output | AW | AND of failing addresses |
| addr_or | output | AW | OR of failing addresses |
| loop_cnt | output | 32 | Compares made |
| fail_cnt | output | 32 | Failures seen |

## Verification
The coincidence that matters is a failing compare on the final address of the window in stop-on-error mode, where the halt decision and the end-of-window decision are made in the same cycle. The bench plants a bit-flip fault at the last address of an ascending sweep, expects the block to park rather than finish, and then expects a single resume to reach done with no further write, loop count unchanged and all logs equal to those of an independent model of the full sweep. A second overlap, abort arriving in the middle of a free-running sweep, is judged by the flags and by the absence of memory strobes afterwards.

// File: rtl/mts_pkg.sv
package mts_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WR   = 3'd1,
      ST_RD   = 3'd2,
      ST_CMP  = 3'd3,
      ST_HALT = 3'd4,
      ST_DONE = 3'd5
   } mts_state_e;
endpackage

// File: rtl/mts_norm.sv
// Corrects the configured window and step before a sweep starts.
module mts_norm #(
   parameter int unsigned AW      = 8,
   parameter int unsigned MEM_LEN = 200,
   localparam int unsigned IW     = AW + 1
) (
   input  logic [AW-1:0]        cfg_lo,
   input  logic [AW-1:0]        cfg_hi,
   input  logic signed [IW-1:0] cfg_inc,
   output logic [AW-1:0]        lo_n,
   output logic [AW-1:0]        hi_n,
   output logic signed [IW-1:0] inc_n,
   output logic [AW-1:0]        first_n
);
   localparam logic [AW-1:0] LAST_A = AW'(MEM_LEN - 1);

   always_comb begin
      hi_n    = (cfg_hi > LAST_A) ? LAST_A : cfg_hi;
      lo_n    = (cfg_lo > hi_n) ? '0 : cfg_lo;
      inc_n   = (cfg_inc == '0) ? IW'(1) : cfg_inc;
      first_n = inc_n[IW-1] ? hi_n : lo_n;
   end
endmodule

// File: rtl/mts_step.sv
// Next address and end-of-window decision for either sweep direction.
module mts_step #(
   parameter int unsigned AW  = 8,
   localparam int unsigned IW = AW + 1,
   localparam int unsigned SW = AW + 2
) (
   input  logic [AW-1:0]        cur,
   input  logic signed [IW-1:0] inc,
   input  logic [AW-1:0]        lo,
   input  logic [AW-1:0]        hi,
   output logic [AW-1:0]        nxt,
   output logic                 past_end
);
   logic signed [SW-1:0] sum;

   always_comb begin
      sum = $signed({2'b00, cur}) + $signed({inc[IW-1], inc});
      nxt = sum[AW-1:0];
      if (inc[IW-1]) past_end = sum < $signed({2'b00, lo});
      else           past_end = sum > $signed({2'b00, hi});
   end
endmodule

// File: rtl/mts_log.sv
// Compare and failure bookkeeping.
module mts_log #(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 8,
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic [DW-1:0] exp_d,
   input  logic [DW-1:0] obs_d,
   input  logic [DW-1:0] mask,
   input  logic [AW-1:0] addr,
   output logic          fail,
   output logic [DW-1:0] should_be,
   output logic [DW-1:0] data_was,
   output logic [DW-1:0] picked,
   output logic [DW-1:0] dropped,
   output logic [AW-1:0] addr_and,
   output logic [AW-1:0] addr_or,
   output logic [CW-1:0] loop_cnt,
   output logic [CW-1:0] fail_cnt
);
   assign fail = |((exp_d ^ obs_d) & mask);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            picked[b]  <= 1'b0;
            dropped[b] <= 1'b0;
         end else if (clr) begin
            picked[b]  <= 1'b0;
            dropped[b] <= 1'b0;
         end else if (upd && mask[b]) begin
            if (!exp_d[b] && obs_d[b]) picked[b]  <= 1'b1;
            if (exp_d[b] && !obs_d[b]) dropped[b] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         should_be <= '0;
         data_was  <= '0;
         addr_and  <= '1;
         addr_or   <= '0;
         loop_cnt  <= '0;
         fail_cnt  <= '0;
      end else if (clr) begin
         should_be <= '0;
         data_was  <= '0;
         addr_and  <= '1;
         addr_or   <= '0;
         loop_cnt  <= '0;
         fail_cnt  <= '0;
      end else if (upd) begin
         loop_cnt <= loop_cnt + 1'b1;
         if (fail) begin
            fail_cnt  <= fail_cnt + 1'b1;
            should_be <= exp_d;
            data_was  <= obs_d;
            addr_and  <= addr_and & addr;
            addr_or   <= addr_or | addr;
         end
      end
   end
endmodule

// File: rtl/mem_test_seq.sv
module mem_test_seq #(
   parameter int unsigned DW      = 16,
   parameter int unsigned AW      = 8,
   parameter int unsigned MEM_LEN = 200,
   localparam int unsigned IW     = AW + 1,
   localparam int unsigned CW     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 resume,
   input  logic                 free_run,
   input  logic                 abort,
   input  logic [AW-1:0]        cfg_lo,
   input  logic [AW-1:0]        cfg_hi,
   input  logic signed [IW-1:0] cfg_inc,
   input  logic [DW-1:0]        cfg_mask,
   input  logic [DW-1:0]        pat_data,
   output logic                 pat_next,
   output logic                 mem_we,
   output logic                 mem_re,
   output logic [AW-1:0]        mem_addr,
   output logic [DW-1:0]        mem_wdata,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 busy,
   output logic                 halted,
   output logic                 done,
   output logic [AW-1:0]        cur_addr,
   output logic [DW-1:0]        should_be,
   output logic [DW-1:0]        data_was,
   output logic [DW-1:0]        bits_picked,
   output logic [DW-1:0]        bits_dropped,
   output logic [AW-1:0]        addr_and,
   output logic [AW-1:0]        addr_or,
   output logic [CW-1:0]        loop_cnt,
   output logic [CW-1:0]        fail_cnt
);
   import mts_pkg::*;

   if (MEM_LEN < 2 || MEM_LEN > (1 << AW)) begin : g_bad_len
      $error("mem_test_seq: MEM_LEN must lie in 2..2**AW");
   end
   if (DW < 1 || AW < 1) begin : g_bad_width
      $error("mem_test_seq: DW and AW must be positive");
   end

   mts_state_e            state_q;
   logic [AW-1:0]         lo_q, hi_q, addr_q, last_q;
   logic [AW-1:0]         lo_n, hi_n, first_n, nxt;
   logic signed [IW-1:0]  inc_q, inc_n;
   logic [DW-1:0]         exp_q, mask_q;
   logic                  free_q, end_q, past_end, fail, go, in_cmp;

   assign go     = start && !abort &&
                   (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_HALT);
   assign in_cmp = (state_q == ST_CMP);

   mts_norm #(.AW(AW), .MEM_LEN(MEM_LEN)) u_norm (
      .cfg_lo (cfg_lo),  .cfg_hi (cfg_hi), .cfg_inc (cfg_inc),
      .lo_n   (lo_n),    .hi_n   (hi_n),   .inc_n   (inc_n),
      .first_n(first_n)
   );

   mts_step #(.AW(AW)) u_step (
      .cur(addr_q), .inc(inc_q), .lo(lo_q), .hi(hi_q),
      .nxt(nxt), .past_end(past_end)
   );

   mts_log #(.DW(DW), .AW(AW), .CW(CW)) u_log (
      .clk      (clk),        .rst_n   (rst_n),
      .clr      (go),         .upd     (in_cmp),
      .exp_d    (exp_q),      .obs_d   (mem_rdata),
      .mask     (mask_q),     .addr    (addr_q),
      .fail     (fail),
      .should_be(should_be),  .data_was(data_was),
      .picked   (bits_picked),.dropped (bits_dropped),
      .addr_and (addr_and),   .addr_or (addr_or),
      .loop_cnt (loop_cnt),   .fail_cnt(fail_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lo_q    <= '0;
         hi_q    <= '0;
         inc_q   <= IW'(1);
         addr_q  <= '0;
         last_q  <= '0;
         exp_q   <= '0;
         mask_q  <= '0;
         free_q  <= 1'b0;
         end_q   <= 1'b0;
      end else if (go) begin
         lo_q    <= lo_n;
         hi_q    <= hi_n;
         inc_q   <= inc_n;
         addr_q  <= first_n;
         mask_q  <= cfg_mask;
         free_q  <= free_run;
         end_q   <= 1'b0;
         state_q <= ST_WR;
      end else if (abort && state_q != ST_DONE) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_WR: begin
               exp_q   <= pat_data;
               state_q <= ST_RD;
            end
            ST_RD:   state_q <= ST_CMP;
            ST_CMP: begin
               last_q <= addr_q;
               addr_q <= nxt;
               end_q  <= past_end;
               if (fail && !free_q) state_q <= ST_HALT;
               else if (past_end)   state_q <= ST_DONE;
               else                 state_q <= ST_WR;
            end
            ST_HALT: begin
               if (resume) begin
                  free_q  <= free_run;
                  mask_q  <= cfg_mask;
                  state_q <= end_q ? ST_DONE : ST_WR;
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   assign pat_next  = in_cmp;
   assign mem_we    = (state_q == ST_WR);
   assign mem_re    = (state_q == ST_RD);
   assign mem_addr  = addr_q;
   assign mem_wdata = pat_data;
   assign busy      = (state_q == ST_WR) || (state_q == ST_RD) || in_cmp;
   assign halted    = (state_q == ST_HALT);
   assign done      = (state_q == ST_DONE);
   assign cur_addr  = last_q;
endmodule

// File: rtl/mts_chk.sv
module mts_chk #(
   parameter int unsigned DW      = 16,
   parameter int unsigned AW      = 8,
   parameter int unsigned MEM_LEN = 200
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_we,
   input logic          mem_re,
   input logic [AW-1:0] mem_addr,
   input logic          busy,
   input logic          halted,
   input logic          done,
   input logic [DW-1:0] bits_picked,
   input logic [AW-1:0] addr_or,
   input logic [31:0]   loop_cnt,
   input logic [31:0]   fail_cnt
);
   localparam logic [AW-1:0] LAST_A = AW'(MEM_LEN - 1);

   AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_re && mem_addr == $past(mem_addr))); // R6
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)); // R6
   AST_WR_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr <= LAST_A)); // R2
   AST_HALT_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> (fail_cnt == $past(fail_cnt) + 32'd1)); // R10
   AST_LOOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (loop_cnt == $past(loop_cnt) || loop_cnt == $past(loop_cnt) + 32'd1)); // R8
   AST_PICK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ((bits_picked & $past(bits_picked)) == $past(bits_picked))); // R7
   AST_OR_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ((addr_or | $past(addr_or)) == addr_or)); // R9
   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, halted, done})); // R12
endmodule

bind mem_test_seq mts_chk #(.DW(DW), .AW(AW), .MEM_LEN(MEM_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re),
   .mem_addr(mem_addr), .busy(busy), .halted(halted), .done(done),
   .bits_picked(bits_picked), .addr_or(addr_or),
   .loop_cnt(loop_cnt), .fail_cnt(fail_cnt)
);

// File: tb/sim_mem_test_seq.sv
module sim_mem_test_seq;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int ML = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, resume = 1'b0, free_run = 1'b0, abort = 1'b0;
   logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
   logic signed [AW:0] cfg_inc = '0;
   logic [DW-1:0] cfg_mask = '0;
   logic [DW-1:0] pat_data;
   logic pat_next, mem_we, mem_re, busy, halted, done;
   logic [AW-1:0] mem_addr, cur_addr, addr_and, addr_or;
   logic [DW-1:0] mem_wdata, should_be, data_was, bits_picked, bits_dropped;
   logic [DW-1:0] mem_rdata = '0;
   logic [31:0] loop_cnt, fail_cnt;

   int total = 0, bad = 0, cycles = 0;
   int pidx = 0, wr_n = 0, seq_bad = 0;
   int wr_log [0:1023];
   logic [DW-1:0] mem [0:255];
   logic prev_we = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   int fa1 = -1, fa2 = -1;
   logic [DW-1:0] fx1 = '0, fx2 = '0;

   // expected results of a full sweep
   int m_loop, m_fail, m_n, m_last;
   logic [DW-1:0] m_pick, m_drop, m_sb, m_dw;
   logic [AW-1:0] m_and, m_or;
   int m_seq [0:255];

   always #5 clk = ~clk;

   mem_test_seq #(.DW(DW), .AW(AW), .MEM_LEN(ML)) u0 (.*);

   function automatic logic [DW-1:0] pat_f(int i);
      logic [31:0] p = i * 32'h1357;
      return 16'hA5C3 ^ p[15:0];
   endfunction

   function automatic logic [DW-1:0] flt(logic [DW-1:0] d, int a);
      logic [DW-1:0] r = d;
      if (a == fa1) r = r ^ fx1;
      if (a == fa2) r = r ^ fx2;
      return r;
   endfunction

   assign pat_data = pat_f(pidx);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         if (wr_n < 1024) wr_log[wr_n] <= int'(mem_addr);
         wr_n <= wr_n + 1;
         if (mem_wdata !== pat_f(pidx)) seq_bad <= seq_bad + 1;
      end
      if (mem_re) begin
         mem_rdata <= flt(mem[mem_addr], int'(mem_addr));
         if (!(prev_we && prev_addr == mem_addr)) seq_bad <= seq_bad + 1;
      end
      if (pat_next) pidx <= pidx + 1;
      prev_we   <= mem_we;
      prev_addr <= mem_addr;
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model(int lo, int hi, int inc, logic [DW-1:0] mask, int p0);
      int h = (hi > ML - 1) ? ML - 1 : hi;
      int l = (lo > h) ? 0 : lo;
      int s = (inc == 0) ? 1 : inc;
      int a = (s > 0) ? l : h;
      m_loop = 0; m_fail = 0; m_n = 0; m_last = 0;
      m_pick = '0; m_drop = '0; m_sb = '0; m_dw = '0; m_and = '1; m_or = '0;
      while (a >= l && a <= h) begin
         logic [DW-1:0] e = pat_f(p0 + m_loop);
         logic [DW-1:0] r = flt(e, a);
         m_seq[m_n] = a; m_n++;
         m_loop++; m_last = a;
         if (((e ^ r) & mask) != '0) begin
            m_fail++;
            m_pick |= ~e & r & mask;
            m_drop |= e & ~r & mask;
            m_sb = e; m_dw = r;
            m_and &= AW'(a); m_or |= AW'(a);
         end
         a += s;
      end
   endtask

   task automatic kick(int lo, int hi, int inc, logic [DW-1:0] mask, logic fr);
      @(negedge clk);
      cfg_lo = AW'(lo); cfg_hi = AW'(hi); cfg_inc = (AW+1)'(inc);
      cfg_mask = mask; free_run = fr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_stop();
      for (int i = 0; i < 4000; i++) begin
         if (done || halted) break;
         @(negedge clk);
      end
   endtask

   task automatic check_final(string req, int w0);
      int mism = 0;
      chk(req, "done", 32'(done), 1);
      chk(req, "loop_cnt", loop_cnt, 32'(m_loop));
      chk(req, "fail_cnt", fail_cnt, 32'(m_fail));
      chk(req, "bits_picked", 32'(bits_picked), 32'(m_pick));
      chk(req, "bits_dropped", 32'(bits_dropped), 32'(m_drop));
      chk(req, "addr_and", 32'(addr_and), 32'(m_and));
      chk(req, "addr_or", 32'(addr_or), 32'(m_or));
      chk(req, "cur_addr", 32'(cur_addr), 32'(m_last));
      if (m_fail > 0) begin
         chk(req, "should_be", 32'(should_be), 32'(m_sb));
         chk(req, "data_was", 32'(data_was), 32'(m_dw));
      end
      for (int k = 0; k < m_n; k++)
         if (wr_log[w0 + k] != m_seq[k]) mism++;
      chk(req, "write order mismatches", 32'(mism), 0);
      chk(req, "write count", 32'(wr_n - w0), 32'(m_n));
   endtask

   task automatic full_run(string req, int lo, int hi, int inc, logic [DW-1:0] mask);
      int p0, w0;
      @(negedge clk);
      p0 = pidx; w0 = wr_n;
      model(lo, hi, inc, mask, p0);
      kick(lo, hi, inc, mask, 1'b1);
      wait_stop();
      check_final(req, w0);
   endtask

   task automatic t_reset();
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "halted/done", 32'({halted, done}), 0);
      chk("R1", "strobes", 32'({mem_we, mem_re}), 0);
      chk("R1", "counters", loop_cnt | fail_cnt, 0);
      chk("R1", "addr_and", 32'(addr_and), 32'hFF);
      chk("R1", "addr_or", 32'(addr_or), 0);
   endtask

   task automatic t_halt();
      int p0, w0;
      fa1 = 4;  fx1 = 16'h00F0;
      fa2 = 15; fx2 = 16'h8001;
      @(negedge clk);
      p0 = pidx; w0 = wr_n;
      model(0, 15, 1, 16'hFFFF, p0);
      kick(0, 15, 1, 16'hFFFF, 1'b0);
      wait_stop();
      chk("R10", "halted at first failure", 32'(halted), 1);
      chk("R10", "loop at first halt", loop_cnt, 5);
      chk("R8", "cur_addr at halt", 32'(cur_addr), 4);
      chk("R8", "should_be", 32'(should_be), 32'(pat_f(p0 + 4)));
      chk("R8", "data_was", 32'(data_was), 32'(pat_f(p0 + 4) ^ 16'h00F0));
      repeat (3) @(negedge clk);
      chk("R10", "stays parked", 32'(wr_n - w0), 5);
      resume = 1'b1; @(negedge clk); resume = 1'b0;
      wait_stop();
      chk("R10", "halted on last address", 32'(halted), 1);
      chk("R9", "addr_and kept over resume", 32'(addr_and), 4);
      chk("R9", "addr_or kept over resume", 32'(addr_or), 15);
      resume = 1'b1; @(negedge clk); resume = 1'b0;
      @(negedge clk);
      check_final("R10", w0);
      fa1 = -1; fa2 = -1;
   endtask

   task automatic t_abort();
      int w;
      kick(0, 199, 1, 16'hFFFF, 1'b1);
      repeat (20) @(negedge clk);
      abort = 1'b1; start = 1'b1; @(negedge clk); abort = 1'b0; start = 1'b0;
      chk("R12", "flags after abort", 32'({busy, halted, done}), 0);
      w = wr_n;
      repeat (6) @(negedge clk);
      chk("R12", "no writes after abort", 32'(wr_n - w), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      full_run("R4", 3, 20, 3, 16'hFFFF);
      full_run("R5", 5, 30, -4, 16'hFFFF);
      full_run("R2", 240, 250, 50, 16'hFFFF);
      full_run("R3", 10, 13, 0, 16'hFFFF);
      t_halt();
      full_run("R9", 0, 5, 1, 16'hFFFF);
      fa1 = 2; fx1 = 16'hFF00; fa2 = 5; fx2 = 16'h0F0F;
      full_run("R7", 0, 7, 1, 16'h00FF);
      fa1 = 22; fx1 = 16'h3000; fa2 = 10; fx2 = 16'h0003;
      full_run("R11", 5, 30, -4, 16'hFFFF);
      fa1 = -1; fa2 = -1;
      t_abort();
      chk("R6", "write/read/pattern sequencing errors", 32'(seq_bad), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule